// File: doc/BRIEF.md
# PAM4 Modulo-4 Precoder and Decoder Pair

This block holds both halves of a PAM4 symbol precoding scheme. On the transmit half, each incoming Gray-coded bit pair is first turned into a level index from 0 to 3. The previous transmitted level is then subtracted from it, modulo 4, which gives the recursion 1/(1+D). The resulting level is Gray-coded again and placed on the line. The receive half undoes this step. It adds the current received level to the previous received level, modulo 4, which is the (1+D) operation. It then turns the sum back into a Gray bit pair.

Each half has its own enable. When the enable is low, that half passes symbols straight through with the same one-cycle latency, so the link can choose whether to use precoding. Each half accepts one symbol in every cycle where its valid input is high. Each half keeps one symbol of history, and that history is always the level seen on the line.

The point of the scheme is how it shapes receiver errors. A single slicer error becomes two adjacent decoded errors. An alternating run of slicer errors, of the kind a one-tap decision-feedback equalizer produces, becomes exactly two decoded errors: one where the run begins and one just after it ends.

Top module: `pam4_precode_link`

## Requirements
- R1: After reset, both output valids are low, both output symbols are 00, and both history levels are 0.
- R2: With the transmit enable high, a valid input produces, one cycle later, an output whose level equals (input level minus previous line level) mod 4. This output level becomes the new transmit history.
- R3: With the receive enable high, a valid input produces, one cycle later, an output whose level equals (input level plus previous received level) mod 4. The input level becomes the new receive history.
- R4: Both halves use the Gray map from bit pair to level: 00→0, 01→1, 11→2, 10→3. Adjacent levels therefore differ in exactly one bit.
- R5: With an enable low, that half outputs its input unchanged one cycle later. Its history still takes the line level, which is the level of that symbol, so a later switch to enabled continues from that history.
- R6: In a cycle with valid low, the history and the output symbol of that half hold their values, and the output valid is low one cycle later.
- R7: With both halves enabled and the transmit output fed unchanged into the receive input, the receive output reproduces the transmit input sequence exactly.
- R8: A single line-level error of +1 or −1 at position k produces exactly two decoded errors, at positions k and k+1.
- R9: An alternating burst of line-level errors (+1,−1,… or −1,+1,…) at positions k to k+L−1 produces exactly two decoded errors, at positions k and k+L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | 1 = precode, 0 = pass through |
| txInValid | input | 1 | Transmit input symbol valid |
| txInBits | input | 2 | Transmit Gray bit pair |
| txOutValid | output | 1 | Transmit output valid |
| txOutSym | output | 2 | Precoded Gray symbol to the line |
| rxEnable | input | 1 | 1 = decode, 0 = pass through |
| rxInValid | input | 1 | Receive input symbol valid |
| rxInSym | input | 2 | Gray symbol from the slicer |
| rxOutValid | output | 1 | Receive output valid |
| rxOutBits | output | 2 | Decoded Gray bit pair |

## Verification
Two functions can coincide in one cycle. The first pair is a history load and a change of enable: the first enabled symbol after a bypassed run must use the line level that the bypassed symbol left behind. The bench provokes this by switching both enables on at the very symbol after a bypass run. The second pair is the two halves accepting symbols in the same cycle, which the bench provokes by driving both halves together. Error shaping is judged by sweeping single errors and alternating bursts of several lengths, both polarities and many start positions through a captured line stream. For each case the bench checks both the count and the positions of the decoded mismatches.

// File: rtl/pam4_precode_pkg.sv
package pam4_precode_pkg;
  localparam int SYM_W = 2;
  typedef logic [SYM_W-1:0] sym_t;

  typedef struct packed {
    logic txLoad;
    logic txApply;
    logic rxLoad;
    logic rxApply;
  } strobe_t;

  // Gray pair to level index, and back (the map is its own inverse form)
  function automatic sym_t grayToLevel(sym_t g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  function automatic sym_t levelToGray(sym_t l);
    return {l[1], l[1] ^ l[0]};
  endfunction

  function automatic sym_t modAdd(sym_t a, sym_t b);
    sym_t s;
    s = a + b;
    return s;
  endfunction

  function automatic sym_t modSub(sym_t a, sym_t b);
    sym_t s;
    s = a - b;
    return s;
  endfunction
endpackage

// File: rtl/pam4_mod4_stage.sv
module pam4_mod4_stage
  import pam4_precode_pkg::*;
#(
  parameter bit IS_DECODER = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  input  logic apply,
  input  sym_t symIn,
  output sym_t symOut
);
  sym_t hist;
  sym_t levelIn;
  sym_t coded;
  sym_t histNext;
  sym_t outNext;

  assign levelIn = grayToLevel(symIn);

  generate
    if (IS_DECODER) begin : g_decode
      always_comb begin
        coded    = modAdd(levelIn, hist);
        histNext = levelIn;
      end
    end else begin : g_precode
      always_comb begin
        coded    = modSub(levelIn, hist);
        histNext = apply ? coded : levelIn;
      end
    end
  endgenerate

  assign outNext = apply ? levelToGray(coded) : symIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist   <= '0;
      symOut <= '0;
    end else if (load) begin
      hist   <= histNext;
      symOut <= outNext;
    end
  end

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(hist) && $stable(symOut)));

  assert_bypass_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (load && !apply) |=> (symOut == $past(symIn)));

  generate
    if (IS_DECODER) begin : g_chk_decode
      assert_rx_decode_R3: assert property (@(posedge clk) disable iff (!rstN)
        (load && apply) |=>
          (modSub(grayToLevel(symOut), $past(hist)) == $past(grayToLevel(symIn))));
      assert_rx_history_R3: assert property (@(posedge clk) disable iff (!rstN)
        load |=> (hist == $past(grayToLevel(symIn))));
    end else begin : g_chk_precode
      assert_tx_precode_R2: assert property (@(posedge clk) disable iff (!rstN)
        (load && apply) |=>
          (modAdd(grayToLevel(symOut), $past(hist)) == $past(grayToLevel(symIn))));
      assert_tx_line_history_R5: assert property (@(posedge clk) disable iff (!rstN)
        load |=> (hist == grayToLevel(symOut)));
    end
  endgenerate
endmodule

// File: rtl/pam4_link_ctrl.sv
module pam4_link_ctrl
  import pam4_precode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    txEnable,
  input  logic    txInValid,
  input  logic    rxEnable,
  input  logic    rxInValid,
  output strobe_t strb,
  output logic    txOutValid,
  output logic    rxOutValid
);
  always_comb begin
    strb.txLoad  = txInValid;
    strb.txApply = txEnable;
    strb.rxLoad  = rxInValid;
    strb.rxApply = rxEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOutValid <= 1'b0;
      rxOutValid <= 1'b0;
    end else begin
      txOutValid <= strb.txLoad;
      rxOutValid <= strb.rxLoad;
    end
  end
endmodule

// File: rtl/pam4_precode_link.sv
module pam4_precode_link
  import pam4_precode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       txInValid,
  input  logic [1:0] txInBits,
  output logic       txOutValid,
  output logic [1:0] txOutSym,
  input  logic       rxEnable,
  input  logic       rxInValid,
  input  logic [1:0] rxInSym,
  output logic       rxOutValid,
  output logic [1:0] rxOutBits
);
  strobe_t strb;

  pam4_link_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEnable   (txEnable),
    .txInValid  (txInValid),
    .rxEnable   (rxEnable),
    .rxInValid  (rxInValid),
    .strb       (strb),
    .txOutValid (txOutValid),
    .rxOutValid (rxOutValid)
  );

  pam4_mod4_stage #(.IS_DECODER(1'b0)) i_precode (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strb.txLoad),
    .apply  (strb.txApply),
    .symIn  (txInBits),
    .symOut (txOutSym)
  );

  pam4_mod4_stage #(.IS_DECODER(1'b1)) i_decode (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strb.rxLoad),
    .apply  (strb.rxApply),
    .symIn  (rxInSym),
    .symOut (rxOutBits)
  );
endmodule

// File: tb/test_pam4_precode_link.sv
`timescale 1ns/1ps
module test_pam4_precode_link;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b0, txInValid = 1'b0, rxEnable = 1'b0, rxInValid = 1'b0;
  logic [1:0] txInBits = 2'b00, rxInSym = 2'b00;
  logic txOutValid, rxOutValid;
  logic [1:0] txOutSym, rxOutBits;

  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pam4_precode_link i_pam4_precode_link (
    .clk(clk), .rstN(rstN),
    .txEnable(txEnable), .txInValid(txInValid), .txInBits(txInBits),
    .txOutValid(txOutValid), .txOutSym(txOutSym),
    .rxEnable(rxEnable), .rxInValid(rxInValid), .rxInSym(rxInSym),
    .rxOutValid(rxOutValid), .rxOutBits(rxOutBits)
  );

  function automatic int bLvl(logic [1:0] g);
    case (g)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] bGray(int l);
    case (((l % 4) + 4) % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic int m4(int v);
    return ((v % 4) + 4) % 4;
  endfunction

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    txInValid = 1'b0; rxInValid = 1'b0;
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  initial begin
    #(20 * 150000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  logic [1:0] lineSym [40];
  logic [1:0] srcSym  [40];

  // Precode a stream, corrupt an alternating burst of length len at pos, decode, count errors
  task automatic runLink(int pos, int len, int firstErr, string req);
    int errCnt, p1, p2, e;
    doReset();
    txEnable = 1'b1; rxEnable = 1'b1;
    for (int i = 0; i < 40; i++) begin
      srcSym[i] = bGray(i * 5 + i / 3);
      txInValid = 1'b1; txInBits = srcSym[i];
      tick();
      lineSym[i] = txOutSym;
    end
    txInValid = 1'b0;
    errCnt = 0; p1 = -1; p2 = -1;
    for (int i = 0; i < 40; i++) begin
      e = 0;
      if (i >= pos && i < pos + len) e = ((i - pos) % 2 == 0) ? firstErr : 4 - firstErr;
      rxInValid = 1'b1; rxInSym = bGray(bLvl(lineSym[i]) + e);
      tick();
      if (len == 0) chk("R7 round trip symbol", rxOutBits, srcSym[i]);
      if (rxOutBits !== srcSym[i]) begin
        errCnt++;
        if (p1 < 0) p1 = i; else if (p2 < 0) p2 = i;
      end
    end
    rxInValid = 1'b0;
    chk({req, " error count"}, errCnt, (len == 0) ? 0 : 2);
    if (len != 0) begin
      chk({req, " entry error position"}, p1, pos);
      chk({req, " exit error position"}, p2, pos + len);
    end
  endtask

  initial begin
    int hist, hist2, expL;
    logic [1:0] s, held;
    tick(); tick();
    // R1 reset state
    chk("R1 tx valid", txOutValid, 0);
    chk("R1 rx valid", rxOutValid, 0);
    chk("R1 tx sym", txOutSym, 0);
    chk("R1 rx bits", rxOutBits, 0);
    rstN = 1'b1;
    // R1 zero history: first enabled symbol passes at its own level
    txEnable = 1'b1; txInValid = 1'b1; txInBits = 2'b11;
    tick();
    chk("R1 tx history zero", txOutSym, 2'b11);

    // R2 R4: exhaustive pairs through the precoder
    doReset(); txEnable = 1'b1; hist = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int j = 0; j < 2; j++) begin
          s = bGray(j ? b : a);
          txInValid = 1'b1; txInBits = s;
          tick();
          expL = m4(bLvl(s) - hist);
          chk("R2 R4 precode", txOutSym, bGray(expL));
          chk("R2 tx valid", txOutValid, 1);
          hist = expL;
        end
    txInValid = 1'b0;

    // R3 R4: exhaustive pairs through the decoder
    doReset(); rxEnable = 1'b1; hist = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int j = 0; j < 2; j++) begin
          s = bGray(j ? b : a);
          rxInValid = 1'b1; rxInSym = s;
          tick();
          chk("R3 R4 decode", rxOutBits, bGray(bLvl(s) + hist));
          hist = bLvl(s);
        end
    rxInValid = 1'b0;

    // R5: bypass on both halves in the same cycle, then enable on the next symbol
    doReset(); txEnable = 1'b0; rxEnable = 1'b0;
    for (int i = 0; i < 8; i++) begin
      txInValid = 1'b1; rxInValid = 1'b1;
      txInBits = bGray(i); rxInSym = bGray(i * 3 + 1);
      tick();
      chk("R5 tx bypass", txOutSym, bGray(i));
      chk("R5 rx bypass", rxOutBits, bGray(i * 3 + 1));
    end
    hist = m4(7); hist2 = m4(7 * 3 + 1);
    txEnable = 1'b1; rxEnable = 1'b1;
    txInBits = 2'b01; rxInSym = 2'b10;
    tick();
    chk("R5 tx history after bypass", txOutSym, bGray(1 - hist));
    chk("R5 rx history after bypass", rxOutBits, bGray(3 + hist2));

    // R6: idle cycles hold history and output
    doReset(); txEnable = 1'b1; rxEnable = 1'b1;
    txInValid = 1'b1; rxInValid = 1'b1; txInBits = 2'b01; rxInSym = 2'b11;
    tick();
    held = txOutSym;
    for (int i = 0; i < 3; i++) begin
      txInValid = 1'b0; rxInValid = 1'b0;
      txInBits = bGray(i + 2); rxInSym = bGray(i);
      tick();
      chk("R6 tx valid low", txOutValid, 0);
      chk("R6 rx valid low", rxOutValid, 0);
      chk("R6 tx sym held", txOutSym, held);
      chk("R6 rx bits held", rxOutBits, 2'b11);
    end
    txInValid = 1'b1; rxInValid = 1'b1; txInBits = 2'b11; rxInSym = 2'b01;
    tick();
    chk("R6 tx history kept", txOutSym, bGray(2 - 1));
    chk("R6 rx history kept", rxOutBits, bGray(1 + 2));
    txInValid = 1'b0; rxInValid = 1'b0;

    // R7 round trip
    runLink(0, 0, 1, "R7");
    // R8 single errors, both polarities, all positions
    for (int k = 0; k < 38; k++) begin
      runLink(k, 1, 1, "R8 +1");
      runLink(k, 1, 3, "R8 -1");
    end
    // R9 alternating bursts
    for (int len = 2; len <= 10; len++)
      for (int k = 1; k < 28; k += 6) begin
        runLink(k, len, 1, "R9 +-");
        runLink(k, len, 3, "R9 -+");
      end

    summary();
    $finish;
  end
endmodule